// File: doc/BRIEF.md
# Memory Bank Select and Read Hold Control

This block sits between a bus master and a set of external memory devices and decides which of up to twelve banks each access belongs to. Every bank owns a base register and an option register. An incoming request address is compared against each valid bank's base under that bank's mask; the lowest-numbered bank that matches gets its one-hot select driven for the access. A request that matches no bank is acknowledged at once with a miss flag and produces no access cycle.

The option register of the selected bank shapes the access. One bit suppresses the data-buffer control strobe (and with it the local write strobe) for that bank. Another bit marks the bank as unable to burst, in which case a burst request is issued as four single beats whose address steps by the beat size, and the request is acknowledged with the last beat. A two-bit code sets how many idle cycles follow a read from the bank before any new request is accepted: code 0 adds none, code 1 adds one, code 2 adds four and code 3 adds eight. Writes never add idle cycles.

Registers are written and read through a small register port addressed by bank number and a select bit. Bank 0's option register has a defined reset value; all other registers reset to zero, so no bank takes part in matching until software programs a base with its valid bit set.

Top module: `mem_bank_sel`

## Requirements
- R1: A request matches bank b when b's base valid bit (base register bit 0) is 1 and, for every compare bit i (address bits 31..15), either mask bit i is 0 or address bit i equals base bit i; a request with no match returns reqAck and reqMiss together one cycle after acceptance, with no accValid.
- R2: The mask may hold any pattern of ones and zeros, so a bank with a cleared mask bit matches both values of that address bit (aliasing into several regions).
- R3: When several banks match, only the lowest-numbered one is selected; accBankSel is one-hot for every access beat.
- R4: bufCtlStrobe is 1 on each access beat of a bank whose buffer-disable bit (option bit 12) is 0 and 0 for a bank where it is 1; localWrStrobe is 1 only on write beats where bufCtlStrobe is 1.
- R5: A burst request to a bank whose burst-inhibit bit (option bit 8) is 0 produces one access beat with accBurst = 1; a single request always gives accBurst = 0.
- R6: A burst request to a bank whose burst-inhibit bit is 1 produces four consecutive beats with accBurst = 0, the first at the request address and each next one 8 higher; reqAck comes with the fourth beat.
- R7: After the last beat of a read that hit a bank, reqReady stays 0 and holdBusy 1 for N cycles counted from the acknowledge cycle, where the hold code in option bits 2..1 gives N = 0, 1, 4, 8 for codes 0, 1, 2, 3; writes and misses give N = 0.
- R8: After reset reqReady = 1, accValid = 0, bank 0's option register reads 0x0000_0100 (burst inhibit set), and every other register reads 0.
- R9: regAddr bits 4..1 pick the bank and bit 0 picks base (0) or option (1); base reads back only bits 31..15 and bit 0, option reads back only bits 31..15, 12, 8 and 2..1, other bits read 0.
- R10: A request is accepted on a clock edge where reqValid and reqReady are both 1; the first access beat (and, for a non-split access, reqAck) appears in the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| regWrEn | input | 1 | Register write strobe |
| regAddr | input | 5 | Bank number in bits 4..1, base/option select in bit 0 |
| regWrData | input | 32 | Register write data |
| regRdData | output | 32 | Register read data for regAddr (combinational) |
| reqValid | input | 1 | Bus request present |
| reqReady | output | 1 | Block can accept a request this cycle |
| reqAddr | input | 32 | Request byte address |
| reqWrite | input | 1 | Request is a write |
| reqBurst | input | 1 | Request is a burst |
| reqAck | output | 1 | Request completed (one-cycle pulse) |
| reqMiss | output | 1 | Request matched no bank (with reqAck) |
| accValid | output | 1 | An access beat is issued this cycle |
| accAddr | output | 32 | Address of the current beat |
| accBankSel | output | 12 | One-hot select of the bank being accessed |
| accBurst | output | 1 | Current beat is a real burst |
| accWrite | output | 1 | Current beat is a write |
| bufCtlStrobe | output | 1 | Data-buffer control strobe |
| localWrStrobe | output | 1 | Local write strobe |
| holdBusy | output | 1 | Idle cycles after a read are being inserted |

## Verification
Address patterns are chosen so each compare path is separated: an exact hit in a fully masked bank, a hit through the cleared mask bit of a bank (alias), a miss on a compared bit right next to the cleared one, a miss just past a small region, a miss on a bank whose valid bit is clear, and an address two banks share, which shows the priority rule before and after the lower bank is disabled. Each of the four hold codes is paired with a read, and the same banks are also hit with writes, which tells the read-only idle insertion apart from a general delay. Single and burst requests are sent to banks with and without the burst-inhibit bit, so a passed-through burst, a split burst with its stepped beat addresses, and a plain single beat are each seen, alongside the buffer strobe on enabled and disabled banks.

// File: rtl/mbs_pkg.sv
package mbs_pkg;

  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic loadReq;   // capture request, issue first beat (or miss)
    logic nextBeat;  // issue next beat of a split burst
    logic ack;       // request completes with the beat issued now
  } ctlStrobe_t;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_SPLIT = 2'd1,
    ST_HOLD  = 2'd2
  } ctlState_t;

  // Option register field positions (little-endian numbering)
  localparam int OPT_BUFDIS_BIT = 12;
  localparam int OPT_NOBURST_BIT = 8;
  localparam int OPT_HOLD_LSB = 1;
  localparam int BASE_VALID_BIT = 0;

  localparam int HOLD_W = 4;

  // Nonlinear read-hold code mapping
  function automatic logic [HOLD_W-1:0] holdCycles(input logic [1:0] code);
    logic [HOLD_W-1:0] n;
    case (code)
      2'b00:   n = 4'd0;
      2'b01:   n = 4'd1;
      2'b10:   n = 4'd4;
      default: n = 4'd8;
    endcase
    return n;
  endfunction

endpackage

// File: rtl/mbs_regfile.sv
module mbs_regfile #(
  parameter int NUM_BANKS = 12,
  parameter int ADDR_W = 32,
  parameter int MASK_W = 17,
  parameter int BANK_IDX_W = $clog2(NUM_BANKS)
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWrEn,
  input  logic [BANK_IDX_W:0]   regAddr,
  input  logic [ADDR_W-1:0]     regWrData,
  output logic [ADDR_W-1:0]     regRdData,
  input  logic [MASK_W-1:0]     cmpAddr,
  output logic                  anyHit,
  output logic [NUM_BANKS-1:0]  hitSel,
  output logic                  hitBufDis,
  output logic                  hitNoBurst,
  output logic [1:0]            hitHold
);
  import mbs_pkg::*;

  localparam logic [BANK_IDX_W:0] NB_L = (BANK_IDX_W+1)'(NUM_BANKS);

  logic [MASK_W-1:0] baseField [NUM_BANKS];
  logic              baseValid [NUM_BANKS];
  logic [MASK_W-1:0] maskField [NUM_BANKS];
  logic              bufDis    [NUM_BANKS];
  logic              noBurst   [NUM_BANKS];
  logic [1:0]        holdCode  [NUM_BANKS];

  logic [BANK_IDX_W-1:0] selBank;
  logic                  selOpt;
  logic [NUM_BANKS-1:0]  bankHit;
  logic [BANK_IDX_W-1:0] hitIdx;
  logic                  unusedWrBits;

  assign selBank = regAddr[BANK_IDX_W:1];
  assign selOpt = regAddr[0];
  assign unusedWrBits = ^regWrData;

  always_ff @(posedge clk) begin
    for (int b = 0; b < NUM_BANKS; b++) begin
      if (!rstN) begin
        baseField[b] <= '0;
        baseValid[b] <= 1'b0;
        maskField[b] <= '0;
        bufDis[b] <= 1'b0;
        noBurst[b] <= (b == 0);
        holdCode[b] <= 2'b00;
      end else if (regWrEn && selBank == BANK_IDX_W'(b)) begin
        if (!selOpt) begin
          baseField[b] <= regWrData[ADDR_W-1 -: MASK_W];
          baseValid[b] <= regWrData[BASE_VALID_BIT];
        end else begin
          maskField[b] <= regWrData[ADDR_W-1 -: MASK_W];
          bufDis[b] <= regWrData[OPT_BUFDIS_BIT];
          noBurst[b] <= regWrData[OPT_NOBURST_BIT];
          holdCode[b] <= regWrData[OPT_HOLD_LSB +: 2];
        end
      end
    end
  end

  // Per-bank masked equality; any mask pattern is allowed
  for (genvar g = 0; g < NUM_BANKS; g++) begin : gMatch
    assign bankHit[g] = baseValid[g] &&
                        (((cmpAddr ^ baseField[g]) & maskField[g]) == '0);
  end

  // Lowest index wins
  always_comb begin
    hitSel = '0;
    hitIdx = '0;
    for (int b = NUM_BANKS - 1; b >= 0; b--) begin
      if (bankHit[b]) begin
        hitSel = '0;
        hitSel[b] = 1'b1;
        hitIdx = BANK_IDX_W'(b);
      end
    end
  end

  assign anyHit = |bankHit;
  assign hitBufDis = bufDis[hitIdx];
  assign hitNoBurst = noBurst[hitIdx];
  assign hitHold = holdCode[hitIdx];

  always_comb begin
    regRdData = '0;
    if ({1'b0, selBank} < NB_L) begin
      if (!selOpt) begin
        regRdData[ADDR_W-1 -: MASK_W] = baseField[selBank];
        regRdData[BASE_VALID_BIT] = baseValid[selBank];
      end else begin
        regRdData[ADDR_W-1 -: MASK_W] = maskField[selBank];
        regRdData[OPT_BUFDIS_BIT] = bufDis[selBank];
        regRdData[OPT_NOBURST_BIT] = noBurst[selBank];
        regRdData[OPT_HOLD_LSB +: 2] = holdCode[selBank];
      end
    end
  end

  // R3: a selected bank always reflects some matching bank
  assert_hit_consistent_R3: assert property (@(posedge clk) disable iff (!rstN)
    anyHit |-> $onehot(hitSel));

endmodule

// File: rtl/mbs_ctrl.sv
module mbs_ctrl #(
  parameter int BURST_BEATS = 4
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  logic                 reqValid,
  input  logic                 reqWrite,
  input  logic                 reqBurst,
  input  logic                 anyHit,
  input  logic                 hitNoBurst,
  input  logic [1:0]           hitHold,
  output mbs_pkg::ctlStrobe_t  strobe,
  output logic                 reqReady,
  output logic                 holdBusy
);
  import mbs_pkg::*;

  localparam int BEAT_CNT_W = $clog2(BURST_BEATS);
  localparam logic [BEAT_CNT_W-1:0] LAST_BEAT = BEAT_CNT_W'(BURST_BEATS - 1);

  ctlState_t state, nextState;
  logic [BEAT_CNT_W-1:0] beatCnt;
  logic [HOLD_W-1:0] holdCnt;
  logic [HOLD_W-1:0] readHold;
  logic splitReq;

  assign readHold = (anyHit && !reqWrite) ? holdCycles(hitHold) : '0;
  assign splitReq = anyHit && reqBurst && hitNoBurst;

  always_comb begin
    strobe = '0;
    nextState = state;
    case (state)
      ST_IDLE: begin
        if (reqValid) begin
          strobe.loadReq = 1'b1;
          if (splitReq) begin
            nextState = ST_SPLIT;
          end else begin
            strobe.ack = 1'b1;
            if (readHold != '0) nextState = ST_HOLD;
          end
        end
      end
      ST_SPLIT: begin
        strobe.nextBeat = 1'b1;
        if (beatCnt == LAST_BEAT) begin
          strobe.ack = 1'b1;
          nextState = (holdCnt != '0) ? ST_HOLD : ST_IDLE;
        end
      end
      ST_HOLD: begin
        if (holdCnt == HOLD_W'(1)) nextState = ST_IDLE;
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state <= ST_IDLE;
      beatCnt <= '0;
      holdCnt <= '0;
    end else begin
      state <= nextState;
      case (state)
        ST_IDLE: begin
          if (reqValid) begin
            beatCnt <= BEAT_CNT_W'(1);
            holdCnt <= readHold;
          end
        end
        ST_SPLIT: beatCnt <= beatCnt + 1'b1;
        ST_HOLD:  holdCnt <= holdCnt - 1'b1;
        default: ;
      endcase
    end
  end

  assign reqReady = (state == ST_IDLE);
  assign holdBusy = (state == ST_HOLD);

  // R7: the hold window never runs with an empty or out-of-range count
  assert_hold_count_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD) |-> (holdCnt != '0 && holdCnt <= HOLD_W'(8)));

  // R7: hold keeps going while more than one idle cycle is left
  assert_hold_persist_R7: assert property (@(posedge clk) disable iff (!rstN)
    (state == ST_HOLD && holdCnt > HOLD_W'(1)) |=> (state == ST_HOLD));

  // R10: a request is only taken while ready
  assert_accept_ready_R10: assert property (@(posedge clk) disable iff (!rstN)
    strobe.loadReq |-> reqReady);

endmodule

// File: rtl/mbs_datapath.sv
module mbs_datapath #(
  parameter int NUM_BANKS = 12,
  parameter int ADDR_W = 32,
  parameter int BEAT_BYTES = 8
) (
  input  logic                 clk,
  input  logic                 rstN,
  input  mbs_pkg::ctlStrobe_t  strobe,
  input  logic [ADDR_W-1:0]    reqAddr,
  input  logic                 reqWrite,
  input  logic                 reqBurst,
  input  logic                 anyHit,
  input  logic [NUM_BANKS-1:0] hitSel,
  input  logic                 hitBufDis,
  input  logic                 hitNoBurst,
  output logic                 reqAck,
  output logic                 reqMiss,
  output logic                 accValid,
  output logic [ADDR_W-1:0]    accAddr,
  output logic [NUM_BANKS-1:0] accBankSel,
  output logic                 accBurst,
  output logic                 accWrite,
  output logic                 bufCtlStrobe,
  output logic                 localWrStrobe
);
  localparam logic [ADDR_W-1:0] BEAT_INC = ADDR_W'(BEAT_BYTES);

  logic [ADDR_W-1:0]    curAddr;
  logic [NUM_BANKS-1:0] curSel;
  logic                 curWrite;
  logic                 curBufDis;
  logic [ADDR_W-1:0]    stepAddr;

  assign stepAddr = curAddr + BEAT_INC;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      curAddr <= '0;
      curSel <= '0;
      curWrite <= 1'b0;
      curBufDis <= 1'b0;
      reqAck <= 1'b0;
      reqMiss <= 1'b0;
      accValid <= 1'b0;
      accAddr <= '0;
      accBankSel <= '0;
      accBurst <= 1'b0;
      accWrite <= 1'b0;
      bufCtlStrobe <= 1'b0;
      localWrStrobe <= 1'b0;
    end else begin
      reqAck <= strobe.ack;
      reqMiss <= 1'b0;
      accValid <= 1'b0;
      accBankSel <= '0;
      accBurst <= 1'b0;
      bufCtlStrobe <= 1'b0;
      localWrStrobe <= 1'b0;
      if (strobe.loadReq) begin
        curAddr <= reqAddr;
        curSel <= hitSel;
        curWrite <= reqWrite;
        curBufDis <= hitBufDis;
        if (anyHit) begin
          accValid <= 1'b1;
          accAddr <= reqAddr;
          accBankSel <= hitSel;
          accBurst <= reqBurst && !hitNoBurst;
          accWrite <= reqWrite;
          bufCtlStrobe <= !hitBufDis;
          localWrStrobe <= !hitBufDis && reqWrite;
        end else begin
          reqMiss <= 1'b1;
        end
      end else if (strobe.nextBeat) begin
        curAddr <= stepAddr;
        accValid <= 1'b1;
        accAddr <= stepAddr;
        accBankSel <= curSel;
        accWrite <= curWrite;
        bufCtlStrobe <= !curBufDis;
        localWrStrobe <= !curBufDis && curWrite;
      end
    end
  end

  // R3: every beat selects exactly one bank
  assert_sel_onehot_R3: assert property (@(posedge clk) disable iff (!rstN)
    accValid |-> $onehot(accBankSel));

  // R4: local write strobe only on buffered write beats
  assert_local_wr_gate_R4: assert property (@(posedge clk) disable iff (!rstN)
    localWrStrobe |-> (bufCtlStrobe && accWrite && accValid));

  // R6: back-to-back beats without an acknowledge step by the beat size
  assert_split_step_R6: assert property (@(posedge clk) disable iff (!rstN)
    (accValid && $past(accValid) && !$past(reqAck)) |->
      (accAddr == $past(accAddr) + BEAT_INC && accBankSel == $past(accBankSel)));

  // R1: a miss acknowledges without an access beat
  assert_miss_no_access_R1: assert property (@(posedge clk) disable iff (!rstN)
    reqMiss |-> (reqAck && !accValid));

endmodule

// File: rtl/mem_bank_sel.sv
module mem_bank_sel #(
  parameter int NUM_BANKS = 12,
  parameter int ADDR_W = 32,
  parameter int MASK_W = 17,
  parameter int BURST_BEATS = 4,
  parameter int BEAT_BYTES = 8
) (
  input  logic                          clk,
  input  logic                          rstN,
  input  logic                          regWrEn,
  input  logic [$clog2(NUM_BANKS):0]    regAddr,
  input  logic [ADDR_W-1:0]             regWrData,
  output logic [ADDR_W-1:0]             regRdData,
  input  logic                          reqValid,
  output logic                          reqReady,
  input  logic [ADDR_W-1:0]             reqAddr,
  input  logic                          reqWrite,
  input  logic                          reqBurst,
  output logic                          reqAck,
  output logic                          reqMiss,
  output logic                          accValid,
  output logic [ADDR_W-1:0]             accAddr,
  output logic [NUM_BANKS-1:0]          accBankSel,
  output logic                          accBurst,
  output logic                          accWrite,
  output logic                          bufCtlStrobe,
  output logic                          localWrStrobe,
  output logic                          holdBusy
);
  import mbs_pkg::*;

  localparam int BANK_IDX_W = $clog2(NUM_BANKS);

  ctlStrobe_t strobe;
  logic anyHit;
  logic [NUM_BANKS-1:0] hitSel;
  logic hitBufDis;
  logic hitNoBurst;
  logic [1:0] hitHold;

  mbs_regfile #(
    .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .MASK_W(MASK_W), .BANK_IDX_W(BANK_IDX_W)
  ) uRegs (
    .clk(clk), .rstN(rstN),
    .regWrEn(regWrEn), .regAddr(regAddr), .regWrData(regWrData), .regRdData(regRdData),
    .cmpAddr(reqAddr[ADDR_W-1 -: MASK_W]),
    .anyHit(anyHit), .hitSel(hitSel), .hitBufDis(hitBufDis),
    .hitNoBurst(hitNoBurst), .hitHold(hitHold)
  );

  mbs_ctrl #(.BURST_BEATS(BURST_BEATS)) uCtrl (
    .clk(clk), .rstN(rstN),
    .reqValid(reqValid), .reqWrite(reqWrite), .reqBurst(reqBurst),
    .anyHit(anyHit), .hitNoBurst(hitNoBurst), .hitHold(hitHold),
    .strobe(strobe), .reqReady(reqReady), .holdBusy(holdBusy)
  );

  mbs_datapath #(
    .NUM_BANKS(NUM_BANKS), .ADDR_W(ADDR_W), .BEAT_BYTES(BEAT_BYTES)
  ) uData (
    .clk(clk), .rstN(rstN), .strobe(strobe),
    .reqAddr(reqAddr), .reqWrite(reqWrite), .reqBurst(reqBurst),
    .anyHit(anyHit), .hitSel(hitSel), .hitBufDis(hitBufDis), .hitNoBurst(hitNoBurst),
    .reqAck(reqAck), .reqMiss(reqMiss),
    .accValid(accValid), .accAddr(accAddr), .accBankSel(accBankSel),
    .accBurst(accBurst), .accWrite(accWrite),
    .bufCtlStrobe(bufCtlStrobe), .localWrStrobe(localWrStrobe)
  );

endmodule

// File: tb/mem_bank_sel_test.sv
`timescale 1ns/1ps
module mem_bank_sel_test;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWrEn = 1'b0;
  logic [4:0] regAddr = '0;
  logic [31:0] regWrData = '0;
  logic [31:0] regRdData;
  logic reqValid = 1'b0;
  logic reqReady;
  logic [31:0] reqAddr = '0;
  logic reqWrite = 1'b0;
  logic reqBurst = 1'b0;
  logic reqAck, reqMiss, accValid, accBurst, accWrite;
  logic [31:0] accAddr;
  logic [11:0] accBankSel;
  logic bufCtlStrobe, localWrStrobe, holdBusy;

  int nChecks = 0;
  int nFails = 0;

  always #2.5 clk = ~clk;

  mem_bank_sel uut (
    .clk(clk), .rstN(rstN), .regWrEn(regWrEn), .regAddr(regAddr),
    .regWrData(regWrData), .regRdData(regRdData),
    .reqValid(reqValid), .reqReady(reqReady), .reqAddr(reqAddr),
    .reqWrite(reqWrite), .reqBurst(reqBurst), .reqAck(reqAck), .reqMiss(reqMiss),
    .accValid(accValid), .accAddr(accAddr), .accBankSel(accBankSel),
    .accBurst(accBurst), .accWrite(accWrite), .bufCtlStrobe(bufCtlStrobe),
    .localWrStrobe(localWrStrobe), .holdBusy(holdBusy)
  );

  typedef struct packed {
    logic [31:0] addr;
    logic        wr;
    logic        burst;
    logic [3:0]  sel;    // 15 = miss
    logic [3:0]  beats;
    logic        burstOut;
    logic        bufOn;
    logic        lwOn;
    logic [3:0]  idle;
  } vec_t;

  localparam int NVEC = 11;
  localparam vec_t VECS [NVEC] = '{
    '{32'h1000_0040, 1'b0, 1'b0, 4'd0,  4'd1, 1'b0, 1'b1, 1'b0, 4'd0},
    '{32'h1000_0040, 1'b1, 1'b1, 4'd0,  4'd1, 1'b1, 1'b1, 1'b1, 4'd0},
    '{32'h2000_0100, 1'b0, 1'b0, 4'd1,  4'd1, 1'b0, 1'b1, 1'b0, 4'd1},
    '{32'h2100_0100, 1'b0, 1'b1, 4'd1,  4'd4, 1'b0, 1'b1, 1'b0, 4'd1},
    '{32'h2000_0100, 1'b1, 1'b1, 4'd1,  4'd4, 1'b0, 1'b1, 1'b1, 4'd0},
    '{32'h2200_0000, 1'b0, 1'b0, 4'd15, 4'd0, 1'b0, 1'b0, 1'b0, 4'd0},
    '{32'h3000_0000, 1'b0, 1'b0, 4'd2,  4'd1, 1'b0, 1'b0, 1'b0, 4'd4},
    '{32'h3000_0008, 1'b1, 1'b0, 4'd2,  4'd1, 1'b0, 1'b0, 1'b0, 4'd0},
    '{32'h4000_0000, 1'b0, 1'b1, 4'd4,  4'd4, 1'b0, 1'b1, 1'b0, 4'd8},
    '{32'h5000_0000, 1'b0, 1'b0, 4'd15, 4'd0, 1'b0, 1'b0, 1'b0, 4'd0},
    '{32'h1000_8000, 1'b0, 1'b0, 4'd15, 4'd0, 1'b0, 1'b0, 1'b0, 4'd0}
  };

  task automatic check(input bit ok, input string req, input logic [31:0] act,
                       input logic [31:0] exp);
    nChecks++;
    if (!ok) begin
      nFails++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", req, act, exp);
    end
  endtask

  task automatic regWrite(input logic [4:0] a, input logic [31:0] d);
    @(negedge clk);
    regWrEn = 1'b1; regAddr = a; regWrData = d;
    @(negedge clk);
    regWrEn = 1'b0;
  endtask

  task automatic regRead(input logic [4:0] a, output logic [31:0] d);
    @(negedge clk);
    regAddr = a;
    #1 d = regRdData;
  endtask

  task automatic runReq(input logic [31:0] a, input logic wr, input logic bst,
                        output logic [3:0] sel, output logic [3:0] beats,
                        output logic bo, output logic bf, output logic lw,
                        output logic [3:0] idle, output bit addrOk,
                        output bit firstValid, output bit missFlag);
    int guard;
    sel = 4'd15; beats = '0; bo = 0; bf = 0; lw = 0; idle = '0;
    addrOk = 1; firstValid = 0; missFlag = 0;
    @(negedge clk);
    reqValid = 1'b1; reqAddr = a; reqWrite = wr; reqBurst = bst;
    while (!reqReady) @(negedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    firstValid = accValid;
    guard = 0;
    forever begin
      if (accValid) begin
        if (beats == 0) begin
          for (int k = 0; k < 12; k++) if (accBankSel[k]) sel = 4'(k);
          bo = accBurst; bf = bufCtlStrobe; lw = localWrStrobe;
        end
        if (accAddr != a + 32'(beats) * 32'd8) addrOk = 0;
        beats++;
      end
      if (reqAck) begin
        missFlag = reqMiss;
        break;
      end
      guard++;
      if (guard > 20) break;
      @(negedge clk);
    end
    guard = 0;
    while (!reqReady && guard < 20) begin
      idle++; guard++;
      @(negedge clk);
    end
  endtask

  initial begin : watchdog
    #200000;
    nChecks++; nFails++;
    $display("FAIL watchdog expired actual=0x0 expected=0x1");
    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

  initial begin : main
    logic [31:0] rd;
    logic [3:0] sel, beats, idle;
    logic bo, bf, lw;
    bit addrOk, firstValid, missFlag;

    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R8: reset state
    check(reqReady === 1'b1, "R8 reqReady after reset", 32'(reqReady), 32'd1);
    check(accValid === 1'b0, "R8 accValid after reset", 32'(accValid), 32'd0);
    regRead(5'b0000_1, rd);
    check(rd === 32'h0000_0100, "R8 bank0 option reset", rd, 32'h0000_0100);
    regRead(5'b0001_1, rd);
    check(rd === 32'h0, "R8 bank1 option reset", rd, 32'h0);
    regRead(5'b0000_0, rd);
    check(rd === 32'h0, "R8 bank0 base reset", rd, 32'h0);
    // R1: nothing matches before programming
    runReq(32'h0000_0000, 1'b0, 1'b0, sel, beats, bo, bf, lw, idle, addrOk, firstValid, missFlag);
    check(missFlag == 1'b1 && beats == 0, "R1 miss before programming", 32'(beats), 32'd0);

    // R9: reserved bits read back as zero
    regWrite(5'b0101_1, 32'hFFFF_FFFF);
    regRead(5'b0101_1, rd);
    check(rd === 32'hFFFF_9106, "R9 option readback", rd, 32'hFFFF_9106);
    regWrite(5'b0101_0, 32'hFFFF_FFFF);
    regRead(5'b0101_0, rd);
    check(rd === 32'hFFFF_8001, "R9 base readback", rd, 32'hFFFF_8001);

    // program banks
    regWrite(5'b0000_0, 32'h1000_0001);
    regWrite(5'b0000_1, 32'hFFFF_8000);
    regWrite(5'b0001_0, 32'h2000_0001);
    regWrite(5'b0001_1, 32'hFEFF_8102);
    regWrite(5'b0010_0, 32'h3000_0001);
    regWrite(5'b0010_1, 32'hFFFF_9004);
    regWrite(5'b0011_0, 32'h3000_0001);
    regWrite(5'b0011_1, 32'hFFFF_8006);
    regWrite(5'b0100_0, 32'h4000_0001);
    regWrite(5'b0100_1, 32'hFFFF_8106);
    regWrite(5'b0101_0, 32'h5000_0000);
    regWrite(5'b0101_1, 32'hFFFF_8000);

    for (int v = 0; v < NVEC; v++) begin
      runReq(VECS[v].addr, VECS[v].wr, VECS[v].burst, sel, beats, bo, bf, lw, idle,
             addrOk, firstValid, missFlag);
      check(sel == VECS[v].sel, $sformatf("R1 R2 R3 bank select vec %0d", v),
            32'(sel), 32'(VECS[v].sel));
      check(beats == VECS[v].beats, $sformatf("R5 R6 beat count vec %0d", v),
            32'(beats), 32'(VECS[v].beats));
      check(bo == VECS[v].burstOut, $sformatf("R5 burst pass vec %0d", v),
            32'(bo), 32'(VECS[v].burstOut));
      check(bf == VECS[v].bufOn && lw == VECS[v].lwOn,
            $sformatf("R4 buffer/local strobes vec %0d", v),
            32'({bf, lw}), 32'({VECS[v].bufOn, VECS[v].lwOn}));
      check(addrOk, $sformatf("R6 beat addresses vec %0d", v), 32'(addrOk), 32'd1);
      check(idle == VECS[v].idle, $sformatf("R7 idle cycles vec %0d", v),
            32'(idle), 32'(VECS[v].idle));
      check(missFlag == (VECS[v].sel == 4'd15), $sformatf("R1 miss flag vec %0d", v),
            32'(missFlag), 32'(VECS[v].sel == 4'd15));
      if (VECS[v].sel != 4'd15)
        check(firstValid, $sformatf("R10 first beat one cycle after accept vec %0d", v),
              32'(firstValid), 32'd1);
    end

    // R3: disable bank 2, shared address falls to bank 3 (hold code 3)
    regWrite(5'b0010_0, 32'h3000_0000);
    runReq(32'h3000_0000, 1'b0, 1'b0, sel, beats, bo, bf, lw, idle, addrOk, firstValid, missFlag);
    check(sel == 4'd3, "R3 next bank after disable", 32'(sel), 32'd3);
    check(idle == 4'd8, "R7 code 3 after priority change", 32'(idle), 32'd8);
    check(bf == 1'b1, "R4 bank3 buffer strobe", 32'(bf), 32'd1);

    // R7: write to hold-8 bank adds no idle cycles
    runReq(32'h4000_0010, 1'b1, 1'b0, sel, beats, bo, bf, lw, idle, addrOk, firstValid, missFlag);
    check(idle == 4'd0, "R7 write adds no idle", 32'(idle), 32'd0);
    check(lw == 1'b1, "R4 write strobe on enabled bank", 32'(lw), 32'd1);

    $display("  == %0d vectors applied, %0d miscompares ==", nChecks, nFails);
    $finish;
  end

endmodule